// File: doc/BRIEF.md
# Isolated-Side Output Watchdog

This block sits on the power side of an isolated channel driver. It receives update events from the logic side, each carrying the on/off state of every channel, and drives the per-channel enable lines from the last accepted update. A separate refresh strobe also arrives from the logic side at a fixed rate, whether or not the host is writing. A refresh carries no data, but it proves the link is alive. Every accepted update or refresh restarts a timer. If the timer runs out, all channels are forced off.

The timer counts microsecond ticks. A prescaler divides the system clock to produce those ticks, and the terminal count defaults to 320 ticks. With those defaults the window falls inside the required 272 µs to 400 µs band. Once the watchdog has fired, a refresh alone does not turn the channels back on. Only a genuine data update re-enables them. The error strobe marks a corrupted transfer in the same cycle. It cancels any update or refresh presented in that cycle, so the enables keep their previous value. It also raises a link-fault flag.

Top module: `chan_guard`

## Requirements
- R1: After reset, `chan_en` is all zeros and both `timed_out` and `link_fault` are low.
- R2: An update strobe without the error strobe loads `upd_data` into `chan_en` on the next clock edge. It also clears `timed_out` and `link_fault`. Bit i of `upd_data` controls channel i, and 1 means on.
- R3: Suppose no accepted update or refresh arrives for exactly `PRESCALE*TIMEOUT_TICKS` clock edges after the last accepted one. Then `timed_out` goes high and `chan_en` goes to zero on that edge, and not on any earlier edge.
- R4: A refresh strobe without the error strobe restarts the timeout window and leaves `chan_en` and `timed_out` unchanged.
- R5: While timed out, refresh strobes keep the outputs off and `timed_out` high. Only an accepted update restores the channels.
- R6: When the error strobe is high, any update or refresh in the same cycle is discarded. `chan_en` keeps its value, the window is not restarted, and `link_fault` rises on the next edge.
- R7: An accepted update or refresh on the edge at which the window would expire takes priority, so no timeout occurs.
- R8: Whenever `timed_out` is high, `chan_en` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_stb | input | 1 | Data update event, one cycle |
| upd_data | input | CH | Channel states carried by the update |
| rfsh_stb | input | 1 | Data-less refresh event, one cycle |
| err_stb | input | 1 | Marks this cycle's transfer as corrupted |
| chan_en | output | CH | Per-channel enable to the drivers |
| timed_out | output | 1 | Watchdog has expired and outputs are forced off |
| link_fault | output | 1 | A corrupted transfer was seen since the last accepted update |

## Verification
Each result appears one cycle after its strobe, because each output is a single register stage. Expiry appears on the edge that completes `PRESCALE*TIMEOUT_TICKS` quiet edges after the restart edge. The bench drives inputs and samples outputs 1 ns after each rising edge, and it counts edges from the restart edge. So it compares exactly the edge at which a result is due, and also the edge just before it. The timeout case is swept over every quiet length from 1 to beyond the window. The update case is swept over all 256 data values.

// File: rtl/chan_guard.sv
module chan_guard #(
  parameter int CH            = 8,
  parameter int PRESCALE      = 100,
  parameter int TIMEOUT_TICKS = 320
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_stb,
  input  logic [CH-1:0] upd_data,
  input  logic          rfsh_stb,
  input  logic          err_stb,
  output logic [CH-1:0] chan_en,
  output logic          timed_out,
  output logic          link_fault
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int TW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [PW-1:0] PRE_LAST  = PW'(PRESCALE - 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(TIMEOUT_TICKS - 1);

  logic [PW-1:0] pre_cnt;
  logic [TW-1:0] tick_cnt;

  wire good_upd = upd_stb & ~err_stb;
  wire restart  = (upd_stb | rfsh_stb) & ~err_stb;
  wire tick     = (pre_cnt == PRE_LAST);
  wire expire   = tick & (tick_cnt == TICK_LAST) & ~timed_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      tick_cnt <= '0;
    end else if (restart) begin
      pre_cnt  <= '0;
      tick_cnt <= '0;
    end else if (!timed_out && !expire) begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick) tick_cnt <= tick_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en   <= '0;
      timed_out <= 1'b0;
    end else if (good_upd) begin
      chan_en   <= upd_data;
      timed_out <= 1'b0;
    end else if (expire && !restart) begin
      chan_en   <= '0;
      timed_out <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        link_fault <= 1'b0;
    else if (err_stb)  link_fault <= 1'b1;
    else if (good_upd) link_fault <= 1'b0;
  end
endmodule

// File: rtl/chan_guard_chk.sv
module chan_guard_chk #(
  parameter int CH            = 8,
  parameter int PRESCALE      = 100,
  parameter int TIMEOUT_TICKS = 320
) (
  input logic          clk,
  input logic          rst_n,
  input logic          upd_stb,
  input logic [CH-1:0] upd_data,
  input logic          rfsh_stb,
  input logic          err_stb,
  input logic [CH-1:0] chan_en,
  input logic          timed_out,
  input logic          link_fault
);
  localparam int WIN = PRESCALE * TIMEOUT_TICKS;
  int unsigned quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) quiet <= 0;
    else if ((upd_stb | rfsh_stb) & ~err_stb) quiet <= 0;
    else if (quiet < WIN) quiet <= quiet + 1;
  end

  assert_off_when_expired_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> chan_en == '0);

  assert_update_applies_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb && !err_stb |=> chan_en == $past(upd_data) && !timed_out && !link_fault);

  assert_refresh_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_stb && !upd_stb && !err_stb |=> $stable(chan_en) && $stable(timed_out));

  assert_error_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_stb |=> link_fault && ($stable(chan_en) || $rose(timed_out)));

  assert_expiry_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timed_out) |-> quiet == WIN);

  assert_expiry_due_R3: assert property (@(posedge clk) disable iff (!rst_n)
    quiet == WIN |-> timed_out);

  assert_refresh_no_revive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out && !(upd_stb && !err_stb) |=> timed_out);
endmodule

bind chan_guard chan_guard_chk #(.CH(CH), .PRESCALE(PRESCALE), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .upd_data(upd_data),
  .rfsh_stb(rfsh_stb), .err_stb(err_stb), .chan_en(chan_en),
  .timed_out(timed_out), .link_fault(link_fault));

// File: tb/chan_guard_test.sv
`timescale 1ns/1ps
module chan_guard_test;
  localparam int CH = 8, P = 3, L = 5, WIN = P * L;

  logic clk = 0, rst_n = 0;
  logic upd_stb = 0, rfsh_stb = 0, err_stb = 0;
  logic [CH-1:0] upd_data = '0;
  logic [CH-1:0] chan_en;
  logic timed_out, link_fault;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chan_guard #(.CH(CH), .PRESCALE(P), .TIMEOUT_TICKS(L)) uut (
    .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .upd_data(upd_data),
    .rfsh_stb(rfsh_stb), .err_stb(err_stb), .chan_en(chan_en),
    .timed_out(timed_out), .link_fault(link_fault));

  task automatic chk(input string req, input logic [CH-1:0] en_e, input logic to_e, input logic lf_e);
    checks++;
    if (chan_en !== en_e || timed_out !== to_e || link_fault !== lf_e) begin
      fails++;
      $display("FAIL %s: chan_en=%h timed_out=%b link_fault=%b expected %h %b %b",
               req, chan_en, timed_out, link_fault, en_e, to_e, lf_e);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) step(); endtask
  task automatic upd(input logic [CH-1:0] d, input logic e);
    upd_stb = 1; upd_data = d; err_stb = e; step(); upd_stb = 0; err_stb = 0;
  endtask
  task automatic rfsh(); rfsh_stb = 1; step(); rfsh_stb = 0; endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(2); #0.5;
    chk("R1", '0, 0, 0);
    rst_n = 1; step();

    // R2: every data value applied one edge after the update
    for (int v = 0; v < 256; v++) begin
      upd(CH'(v), 0);
      chk("R2", CH'(v), 0, 0);
    end

    // R3: sweep quiet lengths; expiry exactly at WIN edges
    for (int n = 1; n <= WIN + 2; n++) begin
      upd(8'hA5, 0);
      idle(n);
      chk("R3", (n >= WIN) ? 8'h00 : 8'hA5, n >= WIN, 0);
      if (n == WIN) chk("R8", 8'h00, 1, 0);
    end

    // R4: refreshes every WIN-1 edges keep channels alive
    upd(8'h3C, 0);
    for (int k = 0; k < 6; k++) begin
      idle(WIN - 2); rfsh();
      chk("R4", 8'h3C, 0, 0);
    end
    idle(WIN - 1); chk("R4", 8'h3C, 0, 0);
    step();        chk("R3", 8'h00, 1, 0);

    // R5: refresh during timeout does not revive
    rfsh(); chk("R5", 8'h00, 1, 0);
    idle(WIN + 1); rfsh(); chk("R5", 8'h00, 1, 0);
    upd(8'h81, 0); chk("R5", 8'h81, 0, 0);

    // R6: corrupted update ignored, window not restarted, fault raised
    upd(8'h0F, 0); idle(10);
    upd(8'hF0, 1); chk("R6", 8'h0F, 0, 1);
    idle(3);       chk("R6", 8'h0F, 0, 1);
    step();        chk("R6", 8'h00, 1, 1);
    rfsh_stb = 1; err_stb = 1; step(); rfsh_stb = 0; err_stb = 0;
    chk("R6", 8'h00, 1, 1);
    upd(8'h55, 0); chk("R2", 8'h55, 0, 0);

    // R7: refresh and update on the expiry edge win
    upd(8'h66, 0); idle(WIN - 1); rfsh(); chk("R7", 8'h66, 0, 0);
    idle(WIN - 1); chk("R7", 8'h66, 0, 0);
    upd(8'h99, 0); chk("R7", 8'h99, 0, 0);
    idle(WIN - 1); chk("R7", 8'h99, 0, 0);
    step();        chk("R8", 8'h00, 1, 0);

    // R1: reset mid-run
    upd(8'hFF, 1);
    rst_n = 0; step(); chk("R1", '0, 0, 0);
    rst_n = 1; idle(WIN - 1); chk("R1", '0, 0, 0);
    step(); chk("R3", '0, 1, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule